// File: doc/BRIEF.md
# Posted-Write Fault Recorder

This block sits beside an I/O bridge and holds the details of the first error that hits a posted write, so that software can inspect them later. Errors reach it in two ways. The bus side reports them as events: either an error signalled after the transaction had already finished, or an error acknowledge. The block also raises errors itself when a write it is tracking stays incomplete for too long. Each event carries the transaction size, a supervisor flag, a read flag and the faulting address. The address may be marked as not usable.

The first error fills a status word and an address word, and the interrupt output goes high. Any error that arrives while that record is held sets only a multiple-error flag. Software reads both words through a small register port. A write to the status word clears the record and drops the interrupt. The write timeout limit is 12.8 µs. It is turned into a cycle count from a clock-frequency parameter.

The event input uses valid/ready. `ev_ready` is always high: an event is taken in the cycle its `ev_valid` is high, and the block never applies back-pressure. The register port, the write-tracking pins and the interrupt are plain level signals.

Top module: `async_fault_latch`

## Requirements
- R1: After reset the status word reads 0x0080_0000 (only the reserved nibble [23:20] = 4'h8), the address word reads 0, and `irq` is low.
- R2: When no fault is held, an accepted event with `ev_kind` 2'b01 (late error) or 2'b10 (error acknowledge) is recorded at that clock edge. The status word gets bit 30 (late) or bit 28 (acknowledge), bit 31 = OR of bits 30..28, [27:25] = size, bit 24 = supervisor, bit 18 = read flag, and bit 17 = `ev_addr_ok`. The address word gets `ev_addr` when `ev_addr_ok` is 1, otherwise 0.
- R3: A write starts with a one-cycle `wr_issue`. If `wr_done` has not been seen after LIMIT = CLK_MHZ*LIMIT_NS/1000 further cycles, the next edge records a timeout. That edge is edge E+LIMIT+1, where E is the issue edge. The status word gets bit 29, the issue's size and supervisor flag, read = 0 and bit 17 = 1, and the address word gets `wr_addr`.
- R4: `wr_done` high at any edge up to and including edge E+LIMIT+1 ends tracking without a fault. A new `wr_issue` restarts the count.
- R5: While a fault is held, every further error sets bit 19 and leaves all other status fields and the address word unchanged.
- R6: If an accepted event and a timeout occur at the same edge while no fault is held, the event is recorded and bit 19 is set.
- R7: `reg_wr` with `reg_sel`=0 clears the record to the reset state. An error at the same edge is then recorded as a fresh first fault, with bit 19 clear.
- R8: `irq` is high exactly while status bit 31 is set. It changes at the same edge as the status word.
- R9: `ev_valid` with `ev_kind` 2'b00 or 2'b11 has no effect, and `reg_wr` with `reg_sel`=1 has no effect (the address word is read-only).
- R10: `ev_ready` is always high, also while a fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | Bus error event present |
| ev_ready | output | 1 | Event accepted (always 1) |
| ev_kind | input | 2 | 01 late error, 10 error acknowledge, others ignored |
| ev_size | input | 3 | Size code of the failing transaction |
| ev_super | input | 1 | Processor was in supervisor mode |
| ev_read | input | 1 | A read was in progress |
| ev_addr_ok | input | 1 | `ev_addr` is meaningful |
| ev_addr | input | ADDR_W | Faulting address |
| wr_issue | input | 1 | A posted write starts (one cycle) |
| wr_size | input | 3 | Size code of that write |
| wr_super | input | 1 | Supervisor flag of that write |
| wr_addr | input | ADDR_W | Address of that write |
| wr_done | input | 1 | The tracked write has completed |
| reg_sel | input | 1 | 0 status word, 1 address word |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Selected word, combinational |
| irq | output | 1 | Fault held |

## Verification
The bench builds the block with its defaults: a 125 MHz clock figure and a 12 800 ns limit, which gives a LIMIT of 1600 cycles. A timeout can therefore be hit one cycle early and one cycle late within a few thousand cycles. Because the clock figure matches the bench clock, the count of 1600 is the real 12.8 µs rather than a shortened stand-in. With a 32-bit address the whole address word is exercised, and the random phase mixes valid and ignored event kinds, clears, and read-only writes against the held/multiple-error rules.

// File: rtl/afault_pkg.sv
package afault_pkg;

  localparam int STAT_W = 32;

  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_LATE = 2'b01,
    EV_ACK  = 2'b10,
    EV_BAD  = 2'b11
  } ev_kind_e;

  localparam logic [3:0] RESV_NIBBLE = 4'h8;

  typedef struct packed {
    logic       late;
    logic       tmo;
    logic       ack;
    logic [2:0] size;
    logic       sup;
    logic       me;
    logic       rd;
    logic       fav;
  } fault_rec_t;

  function automatic logic [STAT_W-1:0] pack_status(input fault_rec_t r);
    logic [STAT_W-1:0] s;
    s        = '0;
    s[31]    = r.late | r.tmo | r.ack;
    s[30]    = r.late;
    s[29]    = r.tmo;
    s[28]    = r.ack;
    s[27:25] = r.size;
    s[24]    = r.sup;
    s[23:20] = RESV_NIBBLE;
    s[19]    = r.me;
    s[18]    = r.rd;
    s[17]    = r.fav;
    return s;
  endfunction

endpackage

// File: rtl/afault_wr_timer.sv
module afault_wr_timer #(
  parameter int CLK_MHZ  = 125,
  parameter int LIMIT_NS = 12800,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        issue_size,
  input  logic              issue_sup,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              done,
  output logic              tmo_fire,
  output logic [2:0]        tmo_size,
  output logic              tmo_sup,
  output logic [ADDR_W-1:0] tmo_addr
);
  localparam int LIMIT = CLK_MHZ * LIMIT_NS / 1000;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic              pending_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        size_q;
  logic              sup_q;
  logic [ADDR_W-1:0] addr_q;

  // The write has been outstanding for LIMIT+1 cycles at this edge.
  assign tmo_fire = pending_q && !done && !issue && (cnt_q == LIMIT_C);
  assign tmo_size = size_q;
  assign tmo_sup  = sup_q;
  assign tmo_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
      size_q    <= '0;
      sup_q     <= 1'b0;
      addr_q    <= '0;
    end else if (issue) begin
      pending_q <= 1'b1;
      cnt_q     <= '0;
      size_q    <= issue_size;
      sup_q     <= issue_sup;
      addr_q    <= issue_addr;
    end else if (pending_q) begin
      if (done || tmo_fire) begin
        pending_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> (cnt_q <= LIMIT_C));

  p_tmo_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> !pending_q);

  p_done_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && done && !issue) |=> !pending_q);

  p_issue_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (pending_q && cnt_q == '0));

endmodule

// File: rtl/afault_capture.sv
module afault_capture
  import afault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ext_fire,
  input  logic [1:0]        ext_kind,
  input  logic [2:0]        ext_size,
  input  logic              ext_sup,
  input  logic              ext_read,
  input  logic              ext_addr_ok,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              tmo_fire,
  input  logic [2:0]        tmo_size,
  input  logic              tmo_sup,
  input  logic [ADDR_W-1:0] tmo_addr,
  output fault_rec_t        rec,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              held
);
  fault_rec_t        rec_q, rec_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              held_q, held_d;

  always_comb begin
    rec_d  = rec_q;
    addr_d = addr_q;
    held_d = held_q;
    if (clr) begin
      rec_d  = '0;
      addr_d = '0;
      held_d = 1'b0;
    end
    if (ext_fire || tmo_fire) begin
      if (!held_d) begin
        held_d = 1'b1;
        if (ext_fire) begin
          rec_d.late = (ext_kind == EV_LATE);
          rec_d.ack  = (ext_kind == EV_ACK);
          rec_d.tmo  = 1'b0;
          rec_d.size = ext_size;
          rec_d.sup  = ext_sup;
          rec_d.rd   = ext_read;
          rec_d.fav  = ext_addr_ok;
          rec_d.me   = tmo_fire;
          addr_d     = ext_addr_ok ? ext_addr : '0;
        end else begin
          rec_d.late = 1'b0;
          rec_d.ack  = 1'b0;
          rec_d.tmo  = 1'b1;
          rec_d.size = tmo_size;
          rec_d.sup  = tmo_sup;
          rec_d.rd   = 1'b0;
          rec_d.fav  = 1'b1;
          rec_d.me   = 1'b0;
          addr_d     = tmo_addr;
        end
      end else begin
        rec_d.me = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      addr_q <= '0;
      held_q <= 1'b0;
    end else begin
      rec_q  <= rec_d;
      addr_q <= addr_d;
      held_q <= held_d;
    end
  end

  assign rec        = rec_q;
  assign fault_addr = addr_q;
  assign held       = held_q;

  p_one_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_q.late, rec_q.tmo, rec_q.ack}));

  p_me_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr && (ext_fire || tmo_fire)) |=> rec_q.me);

  p_keep_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr) |=> ($stable(addr_q) && $stable(rec_q.size) &&
                          $stable(rec_q.late) && $stable(rec_q.tmo) && $stable(rec_q.ack)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ext_fire && !tmo_fire) |=> (!held_q && !rec_q.me && addr_q == '0));

  p_fresh_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ext_fire && !tmo_fire) |=> (held_q && !rec_q.me));

endmodule

// File: rtl/afault_regview.sv
module afault_regview
  import afault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  fault_rec_t        rec,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              sel,
  output logic [STAT_W-1:0] rdata
);
  logic [STAT_W-1:0] status_w;
  logic [STAT_W-1:0] addr_w;

  assign status_w = pack_status(rec);
  assign addr_w   = STAT_W'(fault_addr);

  always_comb begin
    rdata = sel ? addr_w : status_w;
    assert (sel || rdata[23:20] == RESV_NIBBLE) // R1 reserved nibble
      else $error("p_resv_r1 reserved nibble wrong");
  end

endmodule

// File: rtl/async_fault_latch.sv
module async_fault_latch
  import afault_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int LIMIT_NS = 12800,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [2:0]        ev_size,
  input  logic              ev_super,
  input  logic              ev_read,
  input  logic              ev_addr_ok,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              wr_issue,
  input  logic [2:0]        wr_size,
  input  logic              wr_super,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_done,
  input  logic              reg_sel,
  input  logic              reg_wr,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic              ext_fire;
  logic              clr;
  logic              tmo_fire;
  logic [2:0]        tmo_size;
  logic              tmo_sup;
  logic [ADDR_W-1:0] tmo_addr;
  fault_rec_t        rec;
  logic [ADDR_W-1:0] fault_addr;
  logic              held;

  assign ev_ready = 1'b1;
  assign ext_fire = ev_valid && ev_ready &&
                    ((ev_kind == EV_LATE) || (ev_kind == EV_ACK));
  assign clr      = reg_wr && !reg_sel;

  afault_wr_timer #(
    .CLK_MHZ (CLK_MHZ),
    .LIMIT_NS(LIMIT_NS),
    .ADDR_W  (ADDR_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (wr_issue),
    .issue_size(wr_size),
    .issue_sup (wr_super),
    .issue_addr(wr_addr),
    .done      (wr_done),
    .tmo_fire  (tmo_fire),
    .tmo_size  (tmo_size),
    .tmo_sup   (tmo_sup),
    .tmo_addr  (tmo_addr)
  );

  afault_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .ext_fire   (ext_fire),
    .ext_kind   (ev_kind),
    .ext_size   (ev_size),
    .ext_sup    (ev_super),
    .ext_read   (ev_read),
    .ext_addr_ok(ev_addr_ok),
    .ext_addr   (ev_addr),
    .tmo_fire   (tmo_fire),
    .tmo_size   (tmo_size),
    .tmo_sup    (tmo_sup),
    .tmo_addr   (tmo_addr),
    .rec        (rec),
    .fault_addr (fault_addr),
    .held       (held)
  );

  afault_regview #(.ADDR_W(ADDR_W)) u_view (
    .rec       (rec),
    .fault_addr(fault_addr),
    .sel       (reg_sel),
    .rdata     (reg_rdata)
  );

  assign irq = rec.late | rec.tmo | rec.ack;

  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == held);

  p_ignored_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !tmo_fire && ev_valid && (ev_kind == EV_NONE || ev_kind == EV_BAD)) |=> !irq);

  p_ro_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && reg_wr && reg_sel) |=> held);

endmodule

// File: tb/async_fault_latch_bench.sv
module async_fault_latch_bench;
  localparam int CLK_MHZ  = 125;
  localparam int LIMIT_NS = 12800;
  localparam int LIMIT    = CLK_MHZ * LIMIT_NS / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 0, ev_super = 0, ev_read = 0, ev_addr_ok = 0;
  logic [1:0]  ev_kind = 0;
  logic [2:0]  ev_size = 0, wr_size = 0;
  logic [31:0] ev_addr = 0, wr_addr = 0;
  logic        wr_issue = 0, wr_super = 0, wr_done = 0;
  logic        reg_sel = 0, reg_wr = 0;
  logic        ev_ready, irq;
  logic [31:0] reg_rdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  async_fault_latch u_async_fault_latch (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_size(ev_size), .ev_super(ev_super), .ev_read(ev_read),
    .ev_addr_ok(ev_addr_ok), .ev_addr(ev_addr), .wr_issue(wr_issue),
    .wr_size(wr_size), .wr_super(wr_super), .wr_addr(wr_addr), .wr_done(wr_done),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Reference record
  bit         m_held, m_late, m_tmo, m_ack, m_sup, m_me, m_rd, m_fav;
  bit [2:0]   m_size;
  bit [31:0]  m_addr;

  function automatic bit [31:0] exp_status();
    bit [31:0] s = 32'h0080_0000;
    s[31] = m_late | m_tmo | m_ack;
    s[30] = m_late; s[29] = m_tmo; s[28] = m_ack;
    s[27:25] = m_size; s[24] = m_sup;
    s[19] = m_me; s[18] = m_rd; s[17] = m_fav;
    return s;
  endfunction

  task automatic model_clear();
    m_held = 0; m_late = 0; m_tmo = 0; m_ack = 0; m_sup = 0;
    m_me = 0; m_rd = 0; m_fav = 0; m_size = 0; m_addr = 0;
  endtask

  // ext: external event accepted; tmo: timeout at the same edge
  task automatic model_edge(bit clr, bit ext, bit tmo, bit [1:0] k, bit [2:0] sz,
                            bit sp, bit rd, bit aok, bit [31:0] ad,
                            bit [2:0] tsz, bit tsp, bit [31:0] tad);
    if (clr) model_clear();
    if (ext || tmo) begin
      if (m_held) m_me = 1;
      else if (ext) begin
        m_held = 1; m_late = (k == 2'b01); m_ack = (k == 2'b10); m_tmo = 0;
        m_size = sz; m_sup = sp; m_rd = rd; m_fav = aok; m_me = tmo;
        m_addr = aok ? ad : 32'h0;
      end else begin
        m_held = 1; m_late = 0; m_ack = 0; m_tmo = 1; m_size = tsz; m_sup = tsp;
        m_rd = 0; m_fav = 1; m_me = 0; m_addr = tad;
      end
    end
  endtask

  task automatic check(string tag);
    logic [31:0] st, ad;
    reg_sel = 0; #1 st = reg_rdata;
    reg_sel = 1; #1 ad = reg_rdata;
    reg_sel = 0;
    n_chk += 3;
    if (st !== exp_status()) begin
      n_bad++; $display("FAIL %s status act=%h exp=%h", tag, st, exp_status());
    end
    if (ad !== m_addr) begin
      n_bad++; $display("FAIL %s address act=%h exp=%h", tag, ad, m_addr);
    end
    if (irq !== m_held) begin
      n_bad++; $display("FAIL %s (R8) irq act=%b exp=%b", tag, irq, m_held);
    end
  endtask

  // Drive one event/register cycle (called at a negedge), return at the next negedge.
  task automatic ev_cycle(bit v, bit [1:0] k, bit [2:0] sz, bit sp, bit rd, bit aok,
                          bit [31:0] ad, bit wr, bit sel);
    ev_valid = v; ev_kind = k; ev_size = sz; ev_super = sp; ev_read = rd;
    ev_addr_ok = aok; ev_addr = ad; reg_wr = wr; reg_sel = sel;
    n_chk++;
    if (ev_ready !== 1'b1) begin
      n_bad++; $display("FAIL R10 ev_ready act=%b exp=1", ev_ready);
    end
    @(posedge clk);
    model_edge(wr && !sel, v && (k == 2'b01 || k == 2'b10), 0, k, sz, sp, rd, aok, ad,
               0, 0, 0);
    @(negedge clk);
    ev_valid = 0; reg_wr = 0; reg_sel = 0;
  endtask

  task automatic do_clear();
    ev_cycle(0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset");

    // R2 late error with address
    ev_cycle(1, 2'b01, 3'd5, 1, 1, 1, 32'hDEAD_BEE0, 0, 0);
    check("R2 late capture");
    // R5 second error: only ME
    ev_cycle(1, 2'b10, 3'd2, 0, 0, 1, 32'h1234_5678, 0, 0);
    check("R5 multiple");
    // R9 write to address word ignored
    ev_cycle(0, 0, 0, 0, 0, 0, 0, 1, 1);
    check("R9 ro address");
    // R7 clear
    do_clear();
    check("R7 clear");
    // R9 ignored kinds
    ev_cycle(1, 2'b00, 3'd7, 1, 1, 1, 32'hFFFF_FFFF, 0, 0);
    ev_cycle(1, 2'b11, 3'd7, 1, 1, 1, 32'hFFFF_FFFF, 0, 0);
    check("R9 ignored kinds");
    // R2 acknowledge without usable address
    ev_cycle(1, 2'b10, 3'd1, 0, 0, 0, 32'hAAAA_5555, 0, 0);
    check("R2 ack no addr");
    // R7 clear with event in same edge: fresh capture
    ev_cycle(1, 2'b01, 3'd3, 1, 0, 1, 32'h0000_1000, 1, 0);
    check("R7 clear plus event");
    do_clear();

    // R4: done at the last allowed edge
    wr_issue = 1; wr_size = 3'd4; wr_super = 1; wr_addr = 32'h8000_0040;
    @(posedge clk); @(negedge clk); wr_issue = 0;
    repeat (LIMIT) @(negedge clk);
    wr_done = 1;
    @(negedge clk); wr_done = 0;
    repeat (4) @(negedge clk);
    check("R4 done in time");

    // R4: restart by a new issue, then R3 timeout
    wr_issue = 1; @(posedge clk); @(negedge clk);
    repeat (LIMIT - 10) @(negedge clk);
    wr_addr = 32'h8000_0080; wr_size = 3'd6; wr_super = 0;
    wr_issue = 1; @(posedge clk); @(negedge clk); wr_issue = 0;
    repeat (LIMIT) @(negedge clk);
    check("R3 no timeout yet");
    @(negedge clk);
    model_edge(0, 0, 1, 0, 0, 0, 0, 0, 0, 3'd6, 0, 32'h8000_0080);
    check("R3 timeout");
    do_clear();

    // R6: event and timeout at the same edge
    wr_addr = 32'h0000_0F00; wr_size = 3'd2; wr_super = 1;
    wr_issue = 1; @(posedge clk); @(negedge clk); wr_issue = 0;
    repeat (LIMIT) @(negedge clk);
    ev_valid = 1; ev_kind = 2'b10; ev_size = 3'd7; ev_super = 0; ev_read = 1;
    ev_addr_ok = 1; ev_addr = 32'h0BAD_0000;
    @(posedge clk);
    model_edge(0, 1, 1, 2'b10, 3'd7, 0, 1, 1, 32'h0BAD_0000, 3'd2, 1, 32'h0000_0F00);
    @(negedge clk); ev_valid = 0;
    check("R6 simultaneous");
    do_clear();

    // Random phase
    for (int i = 0; i < 300; i++) begin
      bit v, sp, rd, aok, wr, sel;
      bit [1:0] k;
      bit [2:0] sz;
      bit [31:0] ad;
      v = ($urandom % 100) < 45;
      k = 2'($urandom);
      sz = 3'($urandom);
      sp = 1'($urandom); rd = 1'($urandom); aok = ($urandom % 4) != 0;
      ad = $urandom;
      wr = ($urandom % 100) < 15;
      sel = 1'($urandom);
      ev_cycle(v, k, sz, sp, rd, aok, ad, wr, sel);
      check(v ? "R2 R5 R7 R9 random event" : "R7 R9 random idle");
    end

    finish_run();
  end
endmodule